// File: doc/BRIEF.md
# Accumulator ALU with Status Word

This block is the arithmetic core of a small 8-bit controller. It keeps three architectural registers: an accumulator, a B register and a status word. An instruction decoder outside the block presents one operation code and one 8-bit operand per cycle together with a valid strobe. The block then updates the accumulator, B and the flags. Fetch, decode and any memory access for the operand stay outside.

Most operations complete at the clock edge that accepts them. Multiply and divide are computed iteratively over several cycles, a fixed number of operand bits per cycle. While one of them runs, the block raises a busy output and discards any operation that is offered. The status word is a fixed byte. Its lowest bit always shows the parity of the accumulator as it stands, so no instruction has to refresh it.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted and after it is released, the accumulator, B and status word read zero and busy is low.
- R2: Status word bits are: 7 carry (CY), 6 half carry (AC), 5 user flag F0, 4..3 register-bank select, 2 overflow (OV), 1 user flag F1, 0 parity. Operation code 3 (status write) copies operand bits 7..1 into those bits. Operand bit 0 is ignored.
- R3: Status bit 0 equals the XOR of all accumulator bits at every cycle, including right after any accumulator change.
- R4: Code 4 (add) sets A = A + operand. Code 5 (add with carry) also adds CY. CY takes the carry out of bit 7, AC the carry out of bit 3, and OV the XOR of the carries out of bits 6 and 7.
- R5: Code 6 (subtract with borrow) sets A = A - operand - CY. CY takes the borrow out of bit 7, AC the borrow out of bit 3, and OV the XOR of the borrows out of bits 6 and 7.
- R6: Code 1 loads A from the operand and code 2 loads B. Code 7 increments A and code 8 decrements A, both modulo 256. Code 0 and codes 22 to 31 change nothing. None of these codes touches the flags.
- R7: Codes 9, 10 and 11 replace A with A AND, OR and XOR the operand. Code 12 clears A and code 13 complements it. None of them touches the flags.
- R8: Code 14 rotates A left with bit 7 going to bit 0. Code 16 rotates right with bit 0 going to bit 7. Codes 15 and 17 rotate left and right through CY. Only the through-carry forms change CY.
- R9: Code 18 exchanges the two nibbles of A and leaves the flags unchanged.
- R10: Code 19 (decimal adjust) first adds 06h when the low nibble exceeds 9 or AC is set, then adds 60h when the high nibble exceeds 9 or CY is set. CY is set if either addition carries out of bit 7 and is never cleared.
- R11: Code 20 (multiply) forms the 16-bit product A times B, puts the low byte in A and the high byte in B, clears CY, and sets OV exactly when the product exceeds 255.
- R12: Code 21 (divide) puts the quotient of A by B in A and the remainder in B, and clears CY and OV. With B equal to zero it sets OV, clears CY, and leaves A and B unspecified.
- R13: An operation is accepted on an edge where valid is high and busy is low. Multiply and divide raise busy for 4 cycles after acceptance and update A, B and the flags at the 4th edge. Operations offered while busy is high are discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | An operation is offered this cycle |
| op_code | input | 5 | Operation code (see requirements) |
| operand | input | 8 | Second operand or load value |
| acc_o | output | 8 | Accumulator |
| b_o | output | 8 | B register |
| psw_o | output | 8 | Status word with live parity in bit 0 |
| busy_o | output | 1 | Multiply or divide in progress |

## Verification
Two events can meet on one clock edge: a multiply or divide writing its final A, B and flags, and a new operation that the decoder has already placed on the inputs. The stimulus keeps the valid strobe high on most cycles, with random codes, right through every multi-cycle operation, so new operations land on each busy cycle, including the retiring edge. A behavioural reference model tracks a pending-result countdown and discards anything offered while its own count is non-zero. The outputs are compared against this model on every cycle, so a stray write or a lost retirement shows up as a mismatch in A, B or the status word.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

    localparam int DATA_W = 8;

    typedef enum logic [4:0] {
        OP_NOP   = 5'd0,
        OP_LDA   = 5'd1,
        OP_LDB   = 5'd2,
        OP_WRPSW = 5'd3,
        OP_ADD   = 5'd4,
        OP_ADDC  = 5'd5,
        OP_SUBB  = 5'd6,
        OP_INC   = 5'd7,
        OP_DEC   = 5'd8,
        OP_AND   = 5'd9,
        OP_OR    = 5'd10,
        OP_XOR   = 5'd11,
        OP_CLR   = 5'd12,
        OP_CPL   = 5'd13,
        OP_RL    = 5'd14,
        OP_RLC   = 5'd15,
        OP_RR    = 5'd16,
        OP_RRC   = 5'd17,
        OP_SWAP  = 5'd18,
        OP_DA    = 5'd19,
        OP_MUL   = 5'd20,
        OP_DIV   = 5'd21
    } op_e;

    // result of the single-cycle datapath
    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              cy;
        logic              ac;
        logic              ov;
        logic              upd_cy;
        logic              upd_acov;
    } alu_res_t;

    // architectural state held by the top level
    typedef struct packed {
        logic [DATA_W-1:0] acc;
        logic [DATA_W-1:0] b;
        logic              cy;
        logic              ac;
        logic              f0;
        logic [1:0]        rs;
        logic              ov;
        logic              f1;
    } arch_state_t;

endpackage

// File: rtl/acc_alu_logic.sv
module acc_alu_logic
    import acc_alu_pkg::*;
(
    input  op_e               op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] opnd,
    input  logic              cy,
    input  logic              ac,
    output alu_res_t          out
);

    logic       cin;
    logic [8:0] add9, sub9;
    logic [4:0] add4, sub4;
    logic [7:0] add7, sub7;
    logic [8:0] da1, da2;
    logic       da_c1;

    always_comb begin
        cin  = (op == OP_ADD) ? 1'b0 : cy;

        add9 = {1'b0, a} + {1'b0, opnd} + {8'b0, cin};
        add4 = {1'b0, a[3:0]} + {1'b0, opnd[3:0]} + {4'b0, cin};
        add7 = {1'b0, a[6:0]} + {1'b0, opnd[6:0]} + {7'b0, cin};

        sub9 = {1'b0, a} - {1'b0, opnd} - {8'b0, cy};
        sub4 = {1'b0, a[3:0]} - {1'b0, opnd[3:0]} - {4'b0, cy};
        sub7 = {1'b0, a[6:0]} - {1'b0, opnd[6:0]} - {7'b0, cy};

        da1   = {1'b0, a} + (((a[3:0] > 4'd9) || ac) ? 9'h006 : 9'h000);
        da_c1 = cy | da1[8];
        da2   = {1'b0, da1[7:0]} + (((da1[7:4] > 4'd9) || da_c1) ? 9'h060 : 9'h000);
    end

    always_comb begin
        out          = '0;
        out.res      = a;
        out.cy       = cy;
        out.ac       = ac;
        out.upd_cy   = 1'b0;
        out.upd_acov = 1'b0;
        unique case (op)
            OP_ADD, OP_ADDC: begin
                out.res      = add9[7:0];
                out.cy       = add9[8];
                out.ac       = add4[4];
                out.ov       = add7[7] ^ add9[8];
                out.upd_cy   = 1'b1;
                out.upd_acov = 1'b1;
            end
            OP_SUBB: begin
                out.res      = sub9[7:0];
                out.cy       = sub9[8];
                out.ac       = sub4[4];
                out.ov       = sub7[7] ^ sub9[8];
                out.upd_cy   = 1'b1;
                out.upd_acov = 1'b1;
            end
            OP_INC:  out.res = a + 8'd1;
            OP_DEC:  out.res = a - 8'd1;
            OP_AND:  out.res = a & opnd;
            OP_OR:   out.res = a | opnd;
            OP_XOR:  out.res = a ^ opnd;
            OP_CLR:  out.res = '0;
            OP_CPL:  out.res = ~a;
            OP_RL:   out.res = {a[6:0], a[7]};
            OP_RR:   out.res = {a[0], a[7:1]};
            OP_RLC: begin
                out.res    = {a[6:0], cy};
                out.cy     = a[7];
                out.upd_cy = 1'b1;
            end
            OP_RRC: begin
                out.res    = {cy, a[7:1]};
                out.cy     = a[0];
                out.upd_cy = 1'b1;
            end
            OP_SWAP: out.res = {a[3:0], a[7:4]};
            OP_DA: begin
                out.res    = da2[7:0];
                out.cy     = da_c1 | da2[8];
                out.upd_cy = 1'b1;
            end
            default: out.res = a;
        endcase
    end

endmodule

// File: rtl/acc_alu_muldiv.sv
module acc_alu_muldiv
    import acc_alu_pkg::*;
#(
    parameter int STEP_BITS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              is_div,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic              busy_o,
    output logic              done_o,
    output logic [DATA_W-1:0] lo_o,
    output logic [DATA_W-1:0] hi_o,
    output logic              ov_o
);

    localparam int STEPS = DATA_W / STEP_BITS;
    localparam int CW    = $clog2(STEPS + 1);
    localparam int PW    = 2 * DATA_W;

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic              div;
        logic [PW-1:0]     mcand;
        logic [DATA_W-1:0] mplier;
        logic [PW-1:0]     prod;
        logic [DATA_W:0]   rem;
        logic [DATA_W-1:0] quo;
        logic [DATA_W-1:0] dvsr;
    } md_state_t;

    md_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (start) begin
            st_d.cnt    = CW'(STEPS);
            st_d.div    = is_div;
            st_d.mcand  = {{DATA_W{1'b0}}, a};
            st_d.mplier = b;
            st_d.prod   = '0;
            st_d.rem    = '0;
            st_d.quo    = a;
            st_d.dvsr   = b;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - CW'(1);
            for (int j = 0; j < STEP_BITS; j++) begin
                // shift-add multiply, LSB of multiplier first
                if (st_d.mplier[0]) begin
                    st_d.prod = st_d.prod + st_d.mcand;
                end
                st_d.mcand  = {st_d.mcand[PW-2:0], 1'b0};
                st_d.mplier = {1'b0, st_d.mplier[DATA_W-1:1]};
                // restoring divide, MSB of dividend first
                st_d.rem = {st_d.rem[DATA_W-1:0], st_d.quo[DATA_W-1]};
                st_d.quo = {st_d.quo[DATA_W-2:0], 1'b0};
                if (st_d.rem >= {1'b0, st_d.dvsr}) begin
                    st_d.rem    = st_d.rem - {1'b0, st_d.dvsr};
                    st_d.quo[0] = 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        busy_o = (st_q.cnt != '0);
        done_o = (st_q.cnt == CW'(1));
        if (st_q.div) begin
            lo_o = st_d.quo;
            hi_o = st_d.rem[DATA_W-1:0];
            ov_o = (st_q.dvsr == '0);
        end else begin
            lo_o = st_d.prod[DATA_W-1:0];
            hi_o = st_d.prod[PW-1:DATA_W];
            ov_o = |st_d.prod[PW-1:DATA_W];
        end
    end

endmodule

// File: rtl/acc_alu.sv
module acc_alu
    import acc_alu_pkg::*;
#(
    parameter int STEP_BITS = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       op_valid,
    input  logic [4:0] op_code,
    input  logic [7:0] operand,
    output logic [7:0] acc_o,
    output logic [7:0] b_o,
    output logic [7:0] psw_o,
    output logic       busy_o
);

    arch_state_t st_q, st_d;
    op_e         op;
    logic        accept;
    logic        md_start, md_busy, md_done, md_ov;
    logic [7:0]  md_lo, md_hi;
    alu_res_t    alu;

    assign op       = op_e'(op_code);
    assign accept   = op_valid && !md_busy;
    assign md_start = accept && ((op == OP_MUL) || (op == OP_DIV));

    acc_alu_logic u_logic (
        .op   (op),
        .a    (st_q.acc),
        .opnd (operand),
        .cy   (st_q.cy),
        .ac   (st_q.ac),
        .out  (alu)
    );

    acc_alu_muldiv #(.STEP_BITS(STEP_BITS)) u_md (
        .clk    (clk),
        .rst_n  (rst_n),
        .start  (md_start),
        .is_div (op == OP_DIV),
        .a      (st_q.acc),
        .b      (st_q.b),
        .busy_o (md_busy),
        .done_o (md_done),
        .lo_o   (md_lo),
        .hi_o   (md_hi),
        .ov_o   (md_ov)
    );

    always_comb begin
        st_d = st_q;
        if (md_done) begin
            st_d.acc = md_lo;
            st_d.b   = md_hi;
            st_d.cy  = 1'b0;
            st_d.ov  = md_ov;
        end else if (accept) begin
            unique case (op)
                OP_LDA: st_d.acc = operand;
                OP_LDB: st_d.b   = operand;
                OP_WRPSW: begin
                    st_d.cy = operand[7];
                    st_d.ac = operand[6];
                    st_d.f0 = operand[5];
                    st_d.rs = operand[4:3];
                    st_d.ov = operand[2];
                    st_d.f1 = operand[1];
                end
                OP_MUL, OP_DIV: st_d = st_q;
                default: begin
                    st_d.acc = alu.res;
                    if (alu.upd_cy) st_d.cy = alu.cy;
                    if (alu.upd_acov) begin
                        st_d.ac = alu.ac;
                        st_d.ov = alu.ov;
                    end
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign acc_o  = st_q.acc;
    assign b_o    = st_q.b;
    assign psw_o  = {st_q.cy, st_q.ac, st_q.f0, st_q.rs, st_q.ov, st_q.f1, ^st_q.acc};
    assign busy_o = md_busy;

endmodule

// File: rtl/acc_alu_checker.sv
module acc_alu_checker
    import acc_alu_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [4:0] op_code,
    input logic [7:0] operand,
    input logic [7:0] acc_o,
    input logic [7:0] b_o,
    input logic [7:0] psw_o,
    input logic       busy_o
);

    logic take;
    assign take = op_valid && !busy_o;

    a_r13_busy_after_muldiv: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (op_code == OP_MUL || op_code == OP_DIV)) |=> busy_o);

    a_r3_parity_after_load: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_code == OP_LDA) |=> (acc_o == $past(operand)) && (psw_o[0] == ^$past(operand)));

    a_r11_carry_clear_on_retire: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> !psw_o[7]);

    a_r9_swap_nibbles: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_code == OP_SWAP) |=> acc_o == {$past(acc_o[3:0]), $past(acc_o[7:4])});

    a_r8_rotate_left: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_code == OP_RL) |=> acc_o == {$past(acc_o[6:0]), $past(acc_o[7])});

    a_r7_logic_keeps_flags: assert property (@(posedge clk) disable iff (!rst_n)
        (take && (op_code == OP_AND || op_code == OP_OR || op_code == OP_XOR)) |=> $stable(psw_o[7:1]));

    a_r13_bank_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> $stable(psw_o[4:3]) && $stable(b_o) || $fell(busy_o));

    a_r6_ldb_loads: assert property (@(posedge clk) disable iff (!rst_n)
        (take && op_code == OP_LDB) |=> b_o == $past(operand));

endmodule

bind acc_alu acc_alu_checker u_acc_alu_checker (
    .clk      (clk),
    .rst_n    (rst_n),
    .op_valid (op_valid),
    .op_code  (op_code),
    .operand  (operand),
    .acc_o    (acc_o),
    .b_o      (b_o),
    .psw_o    (psw_o),
    .busy_o   (busy_o)
);

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       op_valid;
    logic [4:0] op_code;
    logic [7:0] operand;
    logic [7:0] acc_o, b_o, psw_o;
    logic       busy_o;

    always #2.5 clk = ~clk;

    acc_alu u_acc_alu (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
        .operand(operand), .acc_o(acc_o), .b_o(b_o), .psw_o(psw_o), .busy_o(busy_o)
    );

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    // reference model state
    int m_a = 0, m_b = 0;
    int m_cy = 0, m_ac = 0, m_f0 = 0, m_rs = 0, m_ov = 0, m_f1 = 0;
    int m_pend = 0, p_a = 0, p_b = 0, p_ov = 0;
    bit p_undef = 0, a_undef = 0, b_undef = 0;
    string tag = "R1";

    function automatic int par8(input int v);
        int p = 0;
        for (int i = 0; i < 8; i++) p ^= (v >> i) & 1;
        return p;
    endfunction

    function automatic string req_of(input int op);
        case (op)
            1, 2, 7, 8, 0: return "R6";
            3: return "R2";
            4, 5: return "R4";
            6: return "R5";
            9, 10, 11, 12, 13: return "R7";
            14, 15, 16, 17: return "R8";
            18: return "R9";
            19: return "R10";
            20: return "R11";
            21: return "R12";
            default: return "R6";
        endcase
    endfunction

    task automatic model_edge(input bit v, input int op, input int o);
        int s, t, c1;
        if (m_pend > 0) begin
            m_pend--;
            tag = "R13";
            if (m_pend == 0) begin
                m_a = p_a; m_b = p_b; m_cy = 0; m_ov = p_ov;
                a_undef = p_undef; b_undef = p_undef;
            end
            return;
        end
        if (!v) return;
        tag = req_of(op);
        case (op)
            1: begin m_a = o; a_undef = 0; end
            2: begin m_b = o; b_undef = 0; end
            3: begin
                m_cy = (o >> 7) & 1; m_ac = (o >> 6) & 1; m_f0 = (o >> 5) & 1;
                m_rs = (o >> 3) & 3; m_ov = (o >> 2) & 1; m_f1 = (o >> 1) & 1;
            end
            4, 5: begin
                t = (op == 5) ? m_cy : 0;
                s = m_a + o + t;
                m_ac = ((m_a & 15) + (o & 15) + t) > 15;
                c1 = ((m_a & 127) + (o & 127) + t) > 127;
                m_cy = s > 255;
                m_ov = c1 ^ m_cy;
                m_a = s & 255;
            end
            6: begin
                t = m_cy;
                s = m_a - o - t;
                m_ac = ((m_a & 15) - (o & 15) - t) < 0;
                c1 = ((m_a & 127) - (o & 127) - t) < 0;
                m_cy = s < 0;
                m_ov = c1 ^ m_cy;
                m_a = s & 255;
            end
            7:  m_a = (m_a + 1) & 255;
            8:  m_a = (m_a + 255) & 255;
            9:  m_a = m_a & o;
            10: m_a = m_a | o;
            11: m_a = m_a ^ o;
            12: begin m_a = 0; a_undef = 0; end
            13: m_a = m_a ^ 255;
            14: m_a = ((m_a << 1) | (m_a >> 7)) & 255;
            15: begin t = m_a >> 7; m_a = ((m_a << 1) | m_cy) & 255; m_cy = t; end
            16: m_a = (m_a >> 1) | ((m_a & 1) << 7);
            17: begin t = m_a & 1; m_a = (m_a >> 1) | (m_cy << 7); m_cy = t; end
            18: m_a = ((m_a << 4) | (m_a >> 4)) & 255;
            19: begin
                t = m_a;
                if ((t & 15) > 9 || m_ac) t += 6;
                if (t > 255) m_cy = 1;
                t &= 255;
                if ((t >> 4) > 9 || m_cy) t += 96;
                if (t > 255) m_cy = 1;
                m_a = t & 255;
            end
            20: begin
                s = m_a * m_b;
                p_a = s & 255; p_b = s >> 8; p_ov = s > 255; p_undef = 0;
                m_pend = 4;
            end
            21: begin
                if (m_b == 0) begin p_undef = 1; p_ov = 1; p_a = 0; p_b = 0; end
                else begin p_undef = 0; p_ov = 0; p_a = m_a / m_b; p_b = m_a % m_b; end
                m_pend = 4;
            end
            default: ;
        endcase
    endtask

    task automatic compare(input string r);
        int exp_psw;
        int mask;
        exp_psw = (m_cy << 7) | (m_ac << 6) | (m_f0 << 5) | (m_rs << 3) | (m_ov << 2) | (m_f1 << 1) | par8(m_a);
        mask = a_undef ? 8'hFE : 8'hFF;
        n_chk++;
        if (!a_undef && acc_o !== 8'(m_a)) begin
            n_err++; $display("FAIL %s acc actual %02h expected %02h", r, acc_o, m_a);
        end
        n_chk++;
        if (!b_undef && b_o !== 8'(m_b)) begin
            n_err++; $display("FAIL %s b actual %02h expected %02h", r, b_o, m_b);
        end
        n_chk++;
        if ((psw_o & 8'(mask)) !== 8'(exp_psw & mask)) begin
            n_err++; $display("FAIL %s psw actual %02h expected %02h", r, psw_o, exp_psw & mask);
        end
        n_chk++;
        if (busy_o !== (m_pend > 0)) begin
            n_err++; $display("FAIL R13 busy actual %0b expected %0b", busy_o, m_pend > 0);
        end
    endtask

    task automatic do_op(input bit v, input int op, input int o);
        op_valid = v; op_code = 5'(op); operand = 8'(o);
        @(posedge clk);
        model_edge(v, op, o);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic wait_idle();
        while (m_pend > 0) do_op(0, 0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++; n_err++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; op_valid = 1'b0; op_code = '0; operand = '0;
        repeat (3) @(negedge clk);
        compare("R1");
        rst_n = 1'b1;
        do_op(0, 0, 0); // R1: idle after release
        // R2: status write, operand bit 0 ignored
        do_op(1, 3, 8'hFF);
        do_op(1, 3, 8'h18);
        // R3/R6: load and parity
        do_op(1, 1, 8'h35);
        do_op(1, 2, 8'h07);
        do_op(1, 7, 0);
        do_op(1, 8, 0);
        do_op(1, 25, 8'hAA); // R6: unused code
        // R4: add corners
        do_op(1, 1, 8'h7F); do_op(1, 4, 8'h01);
        do_op(1, 1, 8'hFF); do_op(1, 4, 8'h01);
        do_op(1, 5, 8'h10);
        // R5: subtract with borrow
        do_op(1, 1, 8'h80); do_op(1, 6, 8'h01);
        do_op(1, 1, 8'h00); do_op(1, 6, 8'h01);
        do_op(1, 6, 8'h00);
        // R7, R8, R9
        do_op(1, 9, 8'h0F); do_op(1, 10, 8'hC0); do_op(1, 11, 8'hFF);
        do_op(1, 13, 0); do_op(1, 14, 0); do_op(1, 15, 0);
        do_op(1, 16, 0); do_op(1, 17, 0); do_op(1, 18, 0); do_op(1, 12, 0);
        // R10: decimal adjust
        do_op(1, 3, 0);
        do_op(1, 1, 8'h38); do_op(1, 4, 8'h29); do_op(1, 19, 0);
        do_op(1, 1, 8'h99); do_op(1, 4, 8'h01); do_op(1, 19, 0);
        // R11: multiply overflowing, with offers during busy (R13)
        do_op(1, 1, 8'h80); do_op(1, 2, 8'h02);
        do_op(1, 20, 0);
        do_op(1, 1, 8'h11); do_op(1, 3, 8'hFF); do_op(1, 12, 0); do_op(1, 20, 0);
        do_op(1, 1, 8'h0D); do_op(1, 2, 8'h0B); do_op(1, 20, 0); wait_idle();
        // R12: divide and divide by zero
        do_op(1, 1, 8'hFB); do_op(1, 2, 8'h12); do_op(1, 21, 0); wait_idle();
        do_op(1, 2, 8'h00); do_op(1, 21, 0); wait_idle();
        do_op(1, 1, 8'h5A); do_op(1, 2, 8'h03);
        // mixed random stream
        for (int k = 0; k < 600; k++) begin
            int op, o;
            bit v;
            op = int'($urandom % 32);
            o  = int'($urandom % 256);
            v  = ($urandom % 4) != 0;
            if (op == 21 && m_b == 0) op = 0;
            do_op(v, op, o);
        end
        wait_idle();
        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

endmodule